// File: doc/BRIEF.md
# Lane-Selectable Serial Transmitter with Address Marking

This block turns bytes written by a processor on a 24-bit bus into an asynchronous serial frame. A single byte-wide holding register is written through four aliases selected by `wr_sel`. Three of the aliases choose which byte lane of the bus is captured. Software can therefore unpack a 24-bit word with three writes and no shifting. The fourth alias captures the low lane and marks the byte as an address for multidrop links.

The holding register sits in front of a shift register. As soon as the shifter is idle, a pending byte moves into it and `tx_empty` rises, so the next byte can be written while the current frame is on the line. A frame has a start bit, eight data bits, an optional ninth bit and a stop bit. In 11-bit frames the ninth bit carries either the address mark or a parity bit. Bit timing comes from an external one-cycle `baud_tick` pulse. Mode inputs are sampled when a byte enters the shifter; the address mark is decided when the byte is written.

Top module: `lane_serial_tx`

## Requirements
- R1: After reset, `txd` is 1 and `tx_empty` is 1.
- R2: A write with `wr_sel` = 0, 1 or 2 captures `wr_data` bits 7:0, 15:8 or 23:16, and that byte is the one sent.
- R3: A write with `wr_sel` = 3 captures bits 7:0. When `frame11`=1 and `ninth_parity`=0, the ninth bit of that frame is 1.
- R4: When `frame11`=1 and `ninth_parity`=0, a write with `wr_sel` = 0, 1 or 2 sends the ninth bit as 0.
- R5: The bits leave in this order: start (0), eight data bits, the ninth bit only when `frame11`=1, then stop (1). That makes 11 bits with `frame11`=1 and 10 bits with `frame11`=0.
- R6: Data bits go out LSB first when `msb_first`=0 and MSB first when `msb_first`=1.
- R7: A write clears `tx_empty` on the next clock edge. A pending byte moves into an idle shifter on the following edge, and at that edge `tx_empty` rises and the start bit appears on `txd`.
- R8: A write while `tx_empty`=0 replaces the pending byte. The frame already in the shifter goes out unchanged.
- R9: While idle, `txd` is 1. While a frame is in progress, `txd` changes only on a clock edge where `baud_tick`=1, advancing one bit per tick.
- R10: When `frame11`=1 and `ninth_parity`=1, the ninth bit is the XOR of the eight data bits (even parity), and a `wr_sel`=3 write behaves like a `wr_sel`=0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_sel | input | 2 | Alias: 0 low lane, 1 middle lane, 2 high lane, 3 address alias |
| wr_data | input | 24 | Processor data bus |
| frame11 | input | 1 | 1: 11-bit frame with ninth bit; 0: 10-bit frame |
| ninth_parity | input | 1 | In 11-bit frames, 1: ninth bit is parity; 0: ninth bit is address mark |
| msb_first | input | 1 | Data bit order: 1 MSB first, 0 LSB first |
| baud_tick | input | 1 | One-cycle pulse that ends each bit period |
| txd | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Holding register can accept a byte |

## Verification
The hardest situation to reach is a pending byte that is overwritten while the shifter is busy. The bench loads one byte, which goes straight into the shifter. It then withholds `baud_tick` so the start bit stays on the line, and makes two more writes through different lanes. It then clocks the first frame out and checks that it is intact. Finally it checks that only the second of the pending bytes follows, in the cycle after the stop bit completes.

// File: rtl/lane_serial_tx_pkg.sv
package lane_serial_tx_pkg;
   // Default geometry of the block; modules take them as parameters.
   localparam int unsigned BYTE_W_DEF = 8;
   localparam int unsigned BUS_W_DEF  = 24;

   function automatic int unsigned frame_bits(input int unsigned byte_w, input bit with_ninth);
      return byte_w + (with_ninth ? 3 : 2);
   endfunction
endpackage

// File: rtl/lane_tx_holdreg.sv
module lane_tx_holdreg #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned BUS_W  = 24,
   localparam int unsigned LANES = BUS_W / BYTE_W,
   localparam int unsigned SEL_W = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              addr_mode,
   input  logic              shifter_idle,
   output logic              load,
   output logic [BYTE_W-1:0] hold_byte,
   output logic              hold_mark,
   output logic              empty
);
   localparam int unsigned SLOTS = 2 ** SEL_W;

   logic [BYTE_W-1:0] slot_byte [SLOTS];
   logic              is_alias;

   // Every select code maps to a lane; codes past the lanes fall back to the low lane.
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < LANES) begin : g_lane
         assign slot_byte[s] = wr_data[s*BYTE_W +: BYTE_W];
      end else begin : g_low
         assign slot_byte[s] = wr_data[BYTE_W-1:0];
      end
   end

   assign is_alias = (wr_sel == SEL_W'(LANES));
   assign load     = shifter_idle && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty     <= 1'b1;
         hold_byte <= '0;
         hold_mark <= 1'b0;
      end else begin
         if (load) begin
            empty <= 1'b1;
         end
         if (wr_en) begin
            hold_byte <= slot_byte[wr_sel];
            hold_mark <= addr_mode && is_alias;
            empty     <= 1'b0;
         end
      end
   end

   // R7: a write always leaves a byte pending
   p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !empty);
   // R7: a handoff with no write behind it empties the register
   p_load_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_en) |=> empty);
   // R8: only a write changes the pending byte
   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(hold_byte));
endmodule

// File: rtl/lane_tx_shifter.sv
module lane_tx_shifter #(
   parameter int unsigned BYTE_W     = 8,
   parameter bit          PARITY_ODD = 1'b0,
   localparam int unsigned FRAME_MAX = BYTE_W + 3,
   localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              mark_in,
   input  logic              frame11,
   input  logic              ninth_parity,
   input  logic              msb_first,
   input  logic              baud_tick,
   output logic              txd,
   output logic              idle
);
   logic [BYTE_W-1:0]    reversed;
   logic [BYTE_W-1:0]    ordered;
   logic                 parity_bit;
   logic                 ninth_bit;
   logic [FRAME_MAX-1:0] frame_q;
   logic [CNT_W-1:0]     left_q;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
      assign reversed[i] = byte_in[BYTE_W-1-i];
   end

   if (PARITY_ODD) begin : g_odd
      assign parity_bit = ~^byte_in;
   end else begin : g_even
      assign parity_bit = ^byte_in;
   end

   assign ordered   = msb_first ? reversed : byte_in;
   assign ninth_bit = ninth_parity ? parity_bit : mark_in;
   assign idle      = (left_q == '0);
   assign txd       = idle ? 1'b1 : frame_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         left_q  <= '0;
      end else if (load) begin
         frame_q <= frame11 ? {1'b1, ninth_bit, ordered, 1'b0}
                            : {2'b11, ordered, 1'b0};
         left_q  <= frame11 ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
      end else if (baud_tick && !idle) begin
         frame_q <= {1'b1, frame_q[FRAME_MAX-1:1]};
         left_q  <= left_q - 1'b1;
      end
   end

   // R5: every frame opens with a low start bit
   p_start_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);
   // R9: the line rests high between frames
   p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> txd);
   // R9: no tick, no change on the line
   p_tick_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!baud_tick && !load) |=> $stable(txd));
   // R7: a byte only enters a shifter that has finished
   p_load_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> idle);
endmodule

// File: rtl/lane_serial_tx.sv
module lane_serial_tx
   import lane_serial_tx_pkg::*;
#(
   parameter int unsigned BYTE_W     = BYTE_W_DEF,
   parameter int unsigned BUS_W      = BUS_W_DEF,
   parameter bit          PARITY_ODD = 1'b0,
   localparam int unsigned LANES = BUS_W / BYTE_W,
   localparam int unsigned SEL_W = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             frame11,
   input  logic             ninth_parity,
   input  logic             msb_first,
   input  logic             baud_tick,
   output logic             txd,
   output logic             tx_empty
);
   if (BYTE_W < 1) begin : g_bad_byte
      $error("lane_serial_tx: BYTE_W must be at least 1");
   end
   if (BUS_W % BYTE_W != 0) begin : g_bad_bus
      $error("lane_serial_tx: BUS_W must be a multiple of BYTE_W");
   end
   if (frame_bits(BYTE_W, 1'b1) != BYTE_W + 3) begin : g_bad_frame
      $error("lane_serial_tx: frame length mismatch");
   end

   logic              load;
   logic              shifter_idle;
   logic [BYTE_W-1:0] hold_byte;
   logic              hold_mark;
   logic              addr_mode;

   assign addr_mode = frame11 && !ninth_parity;

   lane_tx_holdreg #(.BYTE_W(BYTE_W), .BUS_W(BUS_W)) u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .addr_mode    (addr_mode),
      .shifter_idle (shifter_idle),
      .load         (load),
      .hold_byte    (hold_byte),
      .hold_mark    (hold_mark),
      .empty        (tx_empty)
   );

   lane_tx_shifter #(.BYTE_W(BYTE_W), .PARITY_ODD(PARITY_ODD)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .byte_in      (hold_byte),
      .mark_in      (hold_mark),
      .frame11      (frame11),
      .ninth_parity (ninth_parity),
      .msb_first    (msb_first),
      .baud_tick    (baud_tick),
      .txd          (txd),
      .idle         (shifter_idle)
   );

   // R1: nothing on the line and nothing pending straight after reset
   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (txd && tx_empty));
endmodule

// File: tb/lane_serial_tx_tb.sv
module lane_serial_tx_tb;
   typedef struct packed {
      logic [1:0]  sel;
      logic [23:0] data;
      logic        f11;
      logic        par;
      logic        msb;
      logic [7:0]  exp_byte;
      logic        exp_ninth;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 24'hC35A81, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0},
      '{2'd1, 24'hC35A81, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0},
      '{2'd2, 24'hC35A81, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b0},
      '{2'd3, 24'hC35A81, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1},
      '{2'd3, 24'hC35A81, 1'b1, 1'b1, 1'b0, 8'h81, 1'b0},
      '{2'd1, 24'hC35A81, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0},
      '{2'd2, 24'h070000, 1'b1, 1'b1, 1'b0, 8'h07, 1'b1},
      '{2'd3, 24'h0000F0, 1'b0, 1'b0, 1'b1, 8'hF0, 1'b0},
      '{2'd0, 24'h00003C, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [23:0] wr_data = '0;
   logic        frame11 = 1'b0;
   logic        ninth_parity = 1'b0;
   logic        msb_first = 1'b0;
   logic        baud_tick = 1'b0;
   logic        txd;
   logic        tx_empty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lane_serial_tx u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .frame11(frame11), .ninth_parity(ninth_parity), .msb_first(msb_first),
      .baud_tick(baud_tick), .txd(txd), .tx_empty(tx_empty)
   );

   function automatic string vec_tag(input int i);
      case (i)
         0: return "R2 R5";
         1: return "R2 R6";
         2: return "R4";
         3: return "R3";
         4: return "R10 alias";
         5: return "R10 R6";
         6: return "R10";
         7: return "R3 10-bit";
         default: return "R4 R6";
      endcase
   endfunction

   // Expected frame, bit k at index k; unused top bit reads 1.
   function automatic logic [10:0] build_frame(input logic [7:0] b, input logic ninth,
                                               input logic f11, input logic msb);
      logic [7:0] ord;
      for (int i = 0; i < 8; i++) ord[i] = msb ? b[7-i] : b[i];
      return f11 ? {1'b1, ninth, ord, 1'b0} : {2'b11, ord, 1'b0};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] sel, input logic [23:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); baud_tick = 1'b1;
      @(negedge clk); baud_tick = 1'b0;
   endtask

   // Called while the start bit is on the line; returns after the last tick.
   task automatic capture(input int nbits, output logic [10:0] got);
      got = '1;
      got[0] = txd;
      for (int k = 1; k < nbits; k++) begin
         tick();
         got[k] = txd;
      end
      tick();
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         report();
      end
   end

   initial begin
      logic [10:0] got;
      repeat (3) @(negedge clk);
      check("R1 txd", {31'd0, txd}, 32'd1);
      check("R1 tx_empty", {31'd0, tx_empty}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         frame11 = VEC[i].f11; ninth_parity = VEC[i].par; msb_first = VEC[i].msb;
         bus_write(VEC[i].sel, VEC[i].data);
         check("R7 empty after write", {31'd0, tx_empty}, 32'd0);
         @(negedge clk);
         check("R7 empty at handoff", {31'd0, tx_empty}, 32'd1);
         capture(VEC[i].f11 ? 11 : 10, got);
         check(vec_tag(i), {21'd0, got},
               {21'd0, build_frame(VEC[i].exp_byte, VEC[i].exp_ninth, VEC[i].f11, VEC[i].msb)});
         check("R9 idle after stop", {31'd0, txd}, 32'd1);
      end

      // R9: a frame in progress holds its bit while no tick arrives
      frame11 = 1'b0; ninth_parity = 1'b0; msb_first = 1'b0;
      bus_write(2'd0, 24'h0000FF);
      @(negedge clk);
      repeat (6) @(negedge clk);
      check("R9 start held without tick", {31'd0, txd}, 32'd0);
      tick();
      check("R9 first data bit after tick", {31'd0, txd}, 32'd1);
      repeat (9) tick();
      check("R9 idle again", {31'd0, txd}, 32'd1);

      // R8: two writes while busy; the shifted frame is intact, the later byte wins
      bus_write(2'd0, 24'h000011);
      @(negedge clk);
      bus_write(2'd1, 24'h002200);
      bus_write(2'd2, 24'h330000);
      check("R8 pending", {31'd0, tx_empty}, 32'd0);
      capture(10, got);
      check("R8 first frame intact", {21'd0, got}, {21'd0, build_frame(8'h11, 1'b0, 1'b0, 1'b0)});
      check("R8 still pending", {31'd0, tx_empty}, 32'd0);
      @(negedge clk);
      check("R7 queued handoff", {31'd0, tx_empty}, 32'd1);
      capture(10, got);
      check("R8 last write sent", {21'd0, got}, {21'd0, build_frame(8'h33, 1'b0, 1'b0, 1'b0)});

      done = 1'b1;
      report();
   end
endmodule